// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Single-Cycle Turn-Off

This block models a synchronous static RAM of 36-bit words as one would place it behind a memory controller. Address, write data, the three chip-enable pins and the write controls are all captured in an input register on the rising clock edge. A read fetches the addressed word into an output register on the following edge and drives it onto the data output bus for one cycle. The bus is a pair of ports: a data vector and a drive-enable flag. The flag stands for the enable of a tri-state pad. The block does not count burst addresses. An external sequencer presents every beat's address, so a new address may be issued on every cycle.

Each word is four lanes of 9 bits. A write either updates a chosen set of lanes or, through the all-lanes write control, the whole word. The output-enable pin and the sleep pin act on the bus without waiting for a clock. Sleep also blocks new commands and keeps the stored words. When the part is deselected, bus drive stops at the first edge after the deselect is captured. A read launched at that same edge would only reach the bus one edge later.

Top module: `sram_scd_core`

## Requirements
- R1: A cycle is a selected cycle only when ce_a_n=0, ce_b=1 and ce_c_n=0 are sampled together at a rising edge; any other combination is a deselect that neither reads nor writes.
- R2: addr, din, the chip enables and the write controls are used only as sampled at the rising clock edge.
- R3: A selected read sampled at edge k sets dq_oe=1 and puts the addressed word on dq_o from edge k+1 to edge k+2; reads on consecutive edges deliver their words on consecutive cycles.
- R4: A read sampled at the edge after a write to the same address returns the newly written word.
- R5: With wr_all_n=1 and wr_byte_n=0, lane i (bits 9*i+8 down to 9*i) is written exactly when lane_sel_n[i]=0, and every other lane keeps its contents.
- R6: A selected cycle with wr_all_n=1 that has wr_byte_n=1, or has wr_byte_n=0 with lane_sel_n=4'b1111, is a read.
- R7: wr_all_n=0 on a selected cycle writes all 36 bits of din, whatever wr_byte_n and lane_sel_n hold.
- R8: When a deselect or a write is sampled at the edge after a read, dq_oe drops at the next edge, so the read's word is driven for exactly one cycle.
- R9: out_en_n=1 forces dq_oe low at once, with no clock edge; returning it to 0 restores the drive of a word still held in the output stage.
- R10: sleep_req=1 forces dq_oe low at once; commands sampled while it is high are ignored, the stored words are kept, and the first edge after it falls accepts a command again.
- R11: During and after reset, dq_oe is 0 and no command is pending.
- R12: dq_o reads all zeros whenever dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr | input | ADDR_W (6) | Word address |
| din | input | 36 | Write data |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | All-lanes write, active low |
| wr_byte_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| dq_o | output | 36 | Read data, zero when not driven |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Several properties are checked on every clock edge. Deselected and sleeping cycles never launch a command. An all-lanes write always carries a full lane mask, and a write request with no lanes selected becomes a read. The bus drives only in the cycle after a launched read and is released one edge after any non-read. Data values are left to the bench's scenarios. These cover read-after-write, lane merging, override of the lane selects, and retention across sleep. The scenarios also confirm the instantaneous effect of the output-enable and sleep pins inside a clock cycle, which an edge-sampled property cannot observe.

// File: rtl/sram_scd_pkg.sv
package sram_scd_pkg;

  // Command held in the input register stage.
  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_READ  = 2'd1,
    SC_WRITE = 2'd2
  } sram_cmd_e;

  // All three enables must sit at their active levels.
  function automatic logic chip_selected(input logic en_a_n,
                                         input logic en_b,
                                         input logic en_c_n);
    return (!en_a_n) && en_b && (!en_c_n);
  endfunction

endpackage

// File: rtl/sram_scd_capture.sv
module sram_scd_capture
  import sram_scd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   din,
  input  logic                      ce_a_n,
  input  logic                      ce_b,
  input  logic                      ce_c_n,
  input  logic                      wr_all_n,
  input  logic                      wr_byte_n,
  input  logic [LANES-1:0]          lane_sel_n,
  input  logic                      sleep_req,
  output sram_cmd_e                 cap_cmd,
  output logic [ADDR_W-1:0]         cap_addr,
  output logic [LANES*LANE_W-1:0]   cap_din,
  output logic [LANES-1:0]          cap_lanes
);

  localparam int unsigned DATA_W = LANES * LANE_W;

  // The all-lanes control wins over the lane selects.
  function automatic logic [LANES-1:0] lane_enables(input logic all_n,
                                                    input logic byte_n,
                                                    input logic [LANES-1:0] sel_n);
    if (!all_n)       return {LANES{1'b1}};
    else if (!byte_n) return ~sel_n;
    else              return {LANES{1'b0}};
  endfunction

  // A selected cycle without any lane to write is a read.
  function automatic sram_cmd_e decode_cmd(input logic selected,
                                           input logic asleep,
                                           input logic [LANES-1:0] lanes);
    if (asleep || !selected) return SC_IDLE;
    else if (|lanes)         return SC_WRITE;
    else                     return SC_READ;
  endfunction

  logic [LANES-1:0] lanes_now;
  logic             sel_now;

  assign lanes_now = lane_enables(wr_all_n, wr_byte_n, lane_sel_n);
  assign sel_now   = chip_selected(ce_a_n, ce_b, ce_c_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_cmd   <= SC_IDLE;
      cap_addr  <= '0;
      cap_din   <= '0;
      cap_lanes <= '0;
    end else begin
      cap_cmd   <= decode_cmd(sel_now, sleep_req, lanes_now);
      cap_addr  <= addr;
      cap_din   <= din;
      cap_lanes <= lanes_now;
    end
  end

  logic unused_w;
  assign unused_w = ^DATA_W;

endmodule

// File: rtl/sram_scd_array.sv
module sram_scd_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [LANES-1:0]          lanes,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  // One storage column per lane, so each lane updates on its own.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic [LANE_W-1:0] lane_rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && lanes[g]) begin
        lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end
      if (rd_en) begin
        lane_rd_q <= lane_mem[addr];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = lane_rd_q;
  end

endmodule

// File: rtl/sram_scd_drive.sv
module sram_scd_drive #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_launch,
  input  logic              out_en_n,
  input  logic              sleep_req,
  input  logic [DATA_W-1:0] rdata,
  output logic              drive_q,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);

  // Set one edge after a read is captured, cleared one edge after
  // anything else is captured.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= rd_launch;
  end

  // Output enable and sleep gate the pad without a clock.
  assign dq_oe = drive_q && !out_en_n && !sleep_req;
  assign dq_o  = dq_oe ? rdata : '0;

endmodule

// File: rtl/sram_scd_core.sv
module sram_scd_core
  import sram_scd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   din,
  input  logic                      ce_a_n,
  input  logic                      ce_b,
  input  logic                      ce_c_n,
  input  logic                      wr_all_n,
  input  logic                      wr_byte_n,
  input  logic [LANES-1:0]          lane_sel_n,
  input  logic                      out_en_n,
  input  logic                      sleep_req,
  output logic [LANES*LANE_W-1:0]   dq_o,
  output logic                      dq_oe
);

  localparam int unsigned DATA_W = LANES * LANE_W;

  sram_cmd_e           cap_cmd;
  logic [ADDR_W-1:0]   cap_addr;
  logic [DATA_W-1:0]   cap_din;
  logic [LANES-1:0]    cap_lanes;
  logic [DATA_W-1:0]   rdata;

  // Named events for the checker.
  logic                rd_launch;
  logic                wr_commit;
  logic [LANES-1:0]    wr_lanes;
  logic                drive_q;

  assign rd_launch = (cap_cmd == SC_READ);
  assign wr_commit = (cap_cmd == SC_WRITE);
  assign wr_lanes  = cap_lanes;

  sram_scd_capture #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .din        (din),
    .ce_a_n     (ce_a_n),
    .ce_b       (ce_b),
    .ce_c_n     (ce_c_n),
    .wr_all_n   (wr_all_n),
    .wr_byte_n  (wr_byte_n),
    .lane_sel_n (lane_sel_n),
    .sleep_req  (sleep_req),
    .cap_cmd    (cap_cmd),
    .cap_addr   (cap_addr),
    .cap_din    (cap_din),
    .cap_lanes  (cap_lanes)
  );

  sram_scd_array #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_array (
    .clk   (clk),
    .wr_en (wr_commit),
    .rd_en (rd_launch),
    .addr  (cap_addr),
    .wdata (cap_din),
    .lanes (cap_lanes),
    .rdata (rdata)
  );

  sram_scd_drive #(
    .DATA_W (DATA_W)
  ) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_launch (rd_launch),
    .out_en_n  (out_en_n),
    .sleep_req (sleep_req),
    .rdata     (rdata),
    .drive_q   (drive_q),
    .dq_o      (dq_o),
    .dq_oe     (dq_oe)
  );

endmodule

// File: rtl/sram_scd_core_chk.sv
module sram_scd_core_chk
  import sram_scd_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_a_n,
  input logic             ce_b,
  input logic             ce_c_n,
  input logic             wr_all_n,
  input logic             wr_byte_n,
  input logic [LANES-1:0] lane_sel_n,
  input logic             sleep_req,
  input logic             dq_oe,
  input logic             rd_launch,
  input logic             wr_commit,
  input logic [LANES-1:0] wr_lanes
);

  logic sel_now;
  assign sel_now = chip_selected(ce_a_n, ce_b, ce_c_n);

  // R1: a deselected cycle launches nothing.
  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_now |=> (!rd_launch && !wr_commit));

  // R7: all-lanes write carries a full mask.
  a_r7_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now && !sleep_req && !wr_all_n) |=> (wr_commit && wr_lanes == {LANES{1'b1}}));

  // R6: a write request with no lane chosen becomes a read.
  a_r6_empty_write_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now && !sleep_req && wr_all_n && (wr_byte_n || (&lane_sel_n)))
      |=> (rd_launch && !wr_commit));

  // R3: the bus drives only in the cycle after a launched read.
  a_r3_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(rd_launch));

  // R8: any non-read releases the bus at the next edge.
  a_r8_single_cycle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_launch |=> !dq_oe);

  // R10: commands sampled in sleep are dropped.
  a_r10_sleep_drops: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> (!rd_launch && !wr_commit));

endmodule

bind sram_scd_core sram_scd_core_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_a_n     (ce_a_n),
  .ce_b       (ce_b),
  .ce_c_n     (ce_c_n),
  .wr_all_n   (wr_all_n),
  .wr_byte_n  (wr_byte_n),
  .lane_sel_n (lane_sel_n),
  .sleep_req  (sleep_req),
  .dq_oe      (dq_oe),
  .rd_launch  (rd_launch),
  .wr_commit  (wr_commit),
  .wr_lanes   (wr_lanes)
);

// File: tb/sram_scd_core_test.sv
module sram_scd_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int LANES      = 4;
  localparam int LANE_W     = 9;
  localparam int DW         = LANES * LANE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0]     din = '0;
  logic              ce_a_n = 1'b1;
  logic              ce_b = 1'b0;
  logic              ce_c_n = 1'b1;
  logic              wr_all_n = 1'b1;
  logic              wr_byte_n = 1'b1;
  logic [LANES-1:0]  lane_sel_n = '1;
  logic              out_en_n = 1'b0;
  logic              sleep_req = 1'b0;
  logic [DW-1:0]     dq_o;
  logic              dq_oe;

  int n_tests = 0;
  int n_fail  = 0;

  sram_scd_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .sleep_req(sleep_req),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL R3 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic put(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                     input logic all_n, input logic byte_n,
                     input logic [LANES-1:0] sel_n, input logic selected);
    addr = a; din = d; wr_all_n = all_n; wr_byte_n = byte_n; lane_sel_n = sel_n;
    ce_a_n = !selected; ce_b = selected; ce_c_n = !selected;
  endtask

  task automatic put_idle();            put('1, '0, 1'b1, 1'b1, '1, 1'b0); endtask
  task automatic put_read(input logic [ADDR_W-1:0] a); put(a, '1, 1'b1, 1'b1, '1, 1'b1); endtask
  task automatic put_wall(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
    put(a, d, 1'b0, 1'b1, '1, 1'b1);
  endtask

  // Single read followed by idle, checking data and the one-cycle drive window.
  task automatic read_chk(input string req, input logic [ADDR_W-1:0] a, input logic [DW-1:0] exp);
    put_read(a); step();
    put_idle();  step();
    chk({req, " drive"}, DW'(dq_oe), DW'(1'b1));
    chk({req, " data"}, dq_o, exp);
    step();
  endtask

  // Expected lane merge, built lane by lane.
  function automatic logic [DW-1:0] merged(input logic [DW-1:0] old_w, input logic [DW-1:0] new_w,
                                           input logic [LANES-1:0] sel_n);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < LANES; i++)
      if (sel_n[i] == 1'b0) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  task automatic t_reset();
    chk("R11 oe in reset", DW'(dq_oe), '0);
    @(negedge clk); rst_n = 1'b1; step();
    chk("R11 oe after reset", DW'(dq_oe), '0);
    chk("R12 bus quiet", dq_o, '0);
  endtask

  task automatic t_read_after_write();
    put_wall(6'd5, 36'h9_A5A5_A5A5); step();
    put_read(6'd5); step();              // R4: read on the very next edge
    put_idle(); step();
    chk("R4 oe", DW'(dq_oe), DW'(1'b1));
    chk("R4 data", dq_o, 36'h9_A5A5_A5A5);
    step();
    chk("R8 off after deselect", DW'(dq_oe), '0);
    chk("R12 bus zero when off", dq_o, '0);
  endtask

  // R3 back-to-back reads; R2 inputs change right after each capture edge.
  task automatic t_burst();
    logic [DW-1:0] pat [4];
    for (int i = 0; i < 4; i++) begin
      pat[i] = {4'(i), 32'h1234_5670 + 32'(i*17)};
      put_wall(6'(8 + i), pat[i]); step();
    end
    for (int i = 0; i < 4; i++) begin
      put_read(6'(8 + i)); step();
      if (i > 0) chk("R3 burst beat", dq_o, pat[i-1]);
    end
    put_idle(); step();
    chk("R3 last beat", dq_o, pat[3]);
    step();
    chk("R8 burst end off", DW'(dq_oe), '0);
  endtask

  task automatic t_lanes();
    logic [DW-1:0] base = 36'h1_2345_6789;
    logic [DW-1:0] upd  = 36'hE_DCBA_9876;
    put_wall(6'd20, base); step();
    put(6'd20, upd, 1'b1, 1'b0, 4'b1010, 1'b1); step();
    read_chk("R5 lanes 0 and 2", 6'd20, merged(base, upd, 4'b1010));
    put(6'd20, upd, 1'b1, 1'b0, 4'b0111, 1'b1); step();
    read_chk("R5 lane 3", 6'd20, merged(merged(base, upd, 4'b1010), upd, 4'b0111));
  endtask

  task automatic t_empty_write();
    put_wall(6'd21, 36'h5_5555_0000); step();
    put(6'd21, 36'hF_FFFF_FFFF, 1'b1, 1'b0, 4'b1111, 1'b1); step();
    put_idle(); step();
    chk("R6 no-lane cycle reads", DW'(dq_oe), DW'(1'b1));
    chk("R6 no-lane data kept", dq_o, 36'h5_5555_0000);
    step();
  endtask

  task automatic t_all_override();
    put_wall(6'd22, 36'h0_0000_0000); step();
    put(6'd22, 36'hA_BCDE_F012, 1'b0, 1'b0, 4'b1110, 1'b1); step();
    read_chk("R7 override lanes", 6'd22, 36'hA_BCDE_F012);
    put(6'd22, 36'h3_3333_3333, 1'b0, 1'b1, 4'b1111, 1'b1); step();
    read_chk("R7 override no byte", 6'd22, 36'h3_3333_3333);
  endtask

  task automatic t_chip_sel();
    put_wall(6'd30, 36'h7_0707_0707); step();
    for (int i = 0; i < 3; i++) begin
      put_wall(6'd30, 36'h0_DEAD_BEEF);
      if (i == 0) ce_a_n = 1'b1;
      if (i == 1) ce_b = 1'b0;
      if (i == 2) ce_c_n = 1'b1;
      step();
    end
    put_read(6'd30); ce_b = 1'b0; step();
    put_idle(); step();
    chk("R1 deselected read no drive", DW'(dq_oe), '0);
    read_chk("R1 deselected writes ignored", 6'd30, 36'h7_0707_0707);
  endtask

  task automatic t_write_after_read();
    put_wall(6'd40, 36'h1_1111_1111); step();
    put_read(6'd40); step();
    put_wall(6'd40, 36'h2_2222_2222); step();
    chk("R8 read word driven", dq_o, 36'h1_1111_1111);
    put_idle(); step();
    chk("R8 write turns bus off", DW'(dq_oe), '0);
    read_chk("R8 write landed", 6'd40, 36'h2_2222_2222);
  endtask

  task automatic t_out_enable();
    put_wall(6'd41, 36'hC_0FFE_E000); step();
    put_read(6'd41); step();
    put_idle(); step();
    out_en_n = 1'b1; #1;
    chk("R9 oe pin off", DW'(dq_oe), '0);
    chk("R12 zero while disabled", dq_o, '0);
    out_en_n = 1'b0; #1;
    chk("R9 oe pin back on", dq_o, 36'hC_0FFE_E000);
    step();
  endtask

  task automatic t_sleep();
    put_wall(6'd50, 36'h8_8888_1111); step();
    put_read(6'd50); step();
    put_idle(); step();
    sleep_req = 1'b1; #1;
    chk("R10 sleep off at once", DW'(dq_oe), '0);
    put_wall(6'd50, 36'h0_BAD0_BAD0); step();
    put_read(6'd50); step();
    put_idle(); step();
    chk("R10 read in sleep ignored", DW'(dq_oe), '0);
    sleep_req = 1'b0;
    read_chk("R10 retained after wake", 6'd50, 36'h8_8888_1111);
  endtask

  initial begin
    t_reset();
    t_read_after_write();
    t_burst();
    t_lanes();
    t_empty_write();
    t_all_override();
    t_chip_sel();
    t_write_after_read();
    t_out_enable();
    t_sleep();
    summary();
    $finish;
  end

endmodule